// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a single-channel SPI master that a processor drives through three 16-bit registers. Writing the data word starts a transfer of one or two bytes on the serial pins. Chip select stays low for the whole transfer. When the last bit has moved, the captured bytes are placed in the data word and a receive-full flag is raised. Software can poll the status word or wait on a single interrupt line.

The control word selects the following:
- byte or word transfers;
- the level SCLK rests at;
- which SCLK edge samples the input;
- a 7-bit divider for the serial clock.

Two interrupt sources, "transfer engine idle" and "receive word waiting", each have their own enable. Both are gated by a module enable. Reading the data word acknowledges it by clearing the receive flag.

Top module: `spi_reg_master`

## Requirements
- R1: After reset, the data, control and status words all read as zero, `cs_n` is high, `sclk` is low and `irq` is low.
- R2: The data word sits at byte offset 0x0, the control word at 0x2 and the status word at 0x4. The status word carries busy in bit 0 and receive-full in bit 1. The control word reads back exactly what was written. Writes to the status word are ignored. Reads of any other offset return zero, and writes to them change nothing.
- R3: A write to the data word while not busy starts a transfer, and busy reads as 1 from the next cycle. `cs_n` is low for the whole transfer. A data write made while busy is ignored and does not disturb the running transfer.
- R4: With control bit 2 set (word mode), bits 15:8 are sent first, then bits 7:0, each byte MSB first. The first received byte lands in bits 15:8 and the second in bits 7:0.
- R5: With control bit 2 clear (byte mode), only bits 7:0 of the written word are sent, MSB first. The received byte is stored in bits 7:0, and bits 15:8 read as zero.
- R6: SCLK rests at the level of control bit 8 whenever no transfer runs. Each SCLK half-period lasts 2×(D+1) system clocks, where D is control bits 15:9.
- R7: With control bit 7 clear, MISO is sampled on the first SCLK edge of each bit and MOSI changes on the second edge. With bit 7 set, MOSI changes on the first edge and MISO is sampled on the second.
- R8: In the cycle a transfer completes, busy clears, receive-full sets and the received word becomes readable at the data offset.
- R9: A read of the data word returns the stored word and clears receive-full. If a transfer completes in the very cycle of that read, the read returns the previous word and receive-full stays set.
- R10: `irq` equals module enable (control bit 0) AND ((NOT busy AND control bit 6) OR (receive-full AND control bit 5)).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of the access |
| irq | output | 1 | Interrupt request, level |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |

## Verification
Two functions can fall in the same clock: the completion of a transfer, which sets receive-full, and a software read of the data word, which clears it. The bench computes the exact completion cycle from the divider and the transfer length. It places a data read on precisely that edge, with a word from an earlier transfer still unread. It then judges that the read returned the older word, that receive-full survived, and that a second read delivers the new word and clears the flag. A data write timed into the middle of a transfer provokes the second overlap, where a new request meets a busy engine; the transmitted and received words must come out untouched.

// File: rtl/spi_reg_master.sv
module spi_reg_master (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        cs_n
);

  localparam logic [2:0] OFF_DATA = 3'd0;
  localparam logic [2:0] OFF_CTRL = 3'd2;
  localparam logic [2:0] OFF_STAT = 3'd4;

  logic [15:0] ctrl_q, data_q, tx_q, rx_q;
  logic        busy_q, full_q, ph_q, mosi_q, w16_q;
  logic [7:0]  hcnt_q;
  logic [4:0]  ecnt_q;

  wire enable   = ctrl_q[0];
  wire mode16   = ctrl_q[2];
  wire ie_rx    = ctrl_q[5];
  wire ie_idle  = ctrl_q[6];
  wire late     = ctrl_q[7];
  wire idle_lvl = ctrl_q[8];

  wire [7:0]  half_last = {ctrl_q[15:9], 1'b1};
  wire        tick      = busy_q && (hcnt_q == half_last);
  wire        first_e   = ~ecnt_q[0];
  wire        samp      = tick && (late ? ~first_e : first_e);
  wire        launch    = tick && (late ? first_e : ~first_e);
  wire [4:0]  e_last    = w16_q ? 5'd31 : 5'd15;
  wire        done      = tick && (ecnt_q == e_last);
  wire [15:0] rx_n      = samp ? {rx_q[14:0], miso} : rx_q;
  wire        wr_data   = bus_wr && (bus_addr == OFF_DATA);
  wire        rd_data   = bus_rd && (bus_addr == OFF_DATA);
  wire        start     = wr_data && !busy_q;
  wire [15:0] load_word = mode16 ? bus_wdata : {bus_wdata[7:0], 8'h00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; data_q <= '0; tx_q <= '0; rx_q <= '0;
      busy_q <= 1'b0; full_q <= 1'b0; ph_q <= 1'b0; mosi_q <= 1'b0;
      w16_q <= 1'b0; hcnt_q <= '0; ecnt_q <= '0;
    end else begin
      if (bus_wr && bus_addr == OFF_CTRL) ctrl_q <= bus_wdata;
      if (start) begin
        busy_q <= 1'b1;
        w16_q  <= mode16;
        hcnt_q <= '0;
        ecnt_q <= '0;
        ph_q   <= 1'b0;
        rx_q   <= '0;
        if (late) tx_q <= load_word;
        else begin
          mosi_q <= load_word[15];
          tx_q   <= {load_word[14:0], 1'b0};
        end
      end else if (busy_q) begin
        hcnt_q <= tick ? 8'd0 : hcnt_q + 8'd1;
        if (tick) begin
          ph_q   <= ~ph_q;
          ecnt_q <= ecnt_q + 5'd1;
          rx_q   <= rx_n;
        end
        if (launch) begin
          mosi_q <= tx_q[15];
          tx_q   <= {tx_q[14:0], 1'b0};
        end
        if (done) begin
          busy_q <= 1'b0;
          data_q <= w16_q ? rx_n : {8'h00, rx_n[7:0]};
        end
      end
      if (done) full_q <= 1'b1;
      else if (rd_data) full_q <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      OFF_DATA: bus_rdata = data_q;
      OFF_CTRL: bus_rdata = ctrl_q;
      OFF_STAT: bus_rdata = {14'd0, full_q, busy_q};
      default:  bus_rdata = 16'd0;
    endcase
  end

  assign irq  = enable && ((!busy_q && ie_idle) || (full_q && ie_rx));
  assign sclk = idle_lvl ^ ph_q;
  assign mosi = mosi_q;
  assign cs_n = ~busy_q;

  assert_idle_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (sclk == ctrl_q[8]));
  assert_start_by_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(bus_wr && bus_addr == OFF_DATA));
  assert_full_on_finish_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_q) |-> ($past(busy_q) && !busy_q));
  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !busy_q) |=> !full_q);
  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[0] |-> !irq);

endmodule

// File: tb/spi_reg_master_tb_top.sv
module spi_reg_master_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic irq, sclk, mosi, miso, cs_n;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  logic cpol_b = 1'b0, cpha_b = 1'b0;
  logic [4:0] idx = 5'd16;
  logic [15:0] spat = '0, cap = '0;
  int edges = 0, e0 = 0, e1 = 0;

  spi_reg_master dut_i (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n));

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  assign miso = (idx < 5'd16) ? spat[idx[3:0]] : 1'b0;

  always @(sclk) if (rst_n === 1'b1) begin
    logic lead;
    lead = (sclk != cpol_b);
    if (cpha_b ? !lead : lead) cap = {cap[14:0], mosi};
    else idx = idx - 5'd1;
    if (edges == 0) e0 = cyc;
    if (edges == 1) e1 = cyc;
    edges++;
  end

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] v);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a; #0.5 v = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(3'd4, s);
      if (!s[0]) break;
    end
  endtask

  function automatic logic [15:0] mk_ctrl(logic [6:0] dv, logic pol, logic pha,
      logic iei, logic ier, logic m16, logic en);
    return {dv, pol, pha, iei, ier, 2'b00, m16, 1'b0, en};
  endfunction

  function automatic logic [15:0] exp_rx(logic m16, logic [15:0] p);
    return m16 ? p : {8'h00, p[15:8]};
  endfunction

  function automatic logic [15:0] exp_tx(logic m16, logic [15:0] w);
    return m16 ? w : {8'h00, w[7:0]};
  endfunction

  task automatic setup(logic [15:0] c, logic [15:0] p);
    wr(3'd2, c);
    cpol_b = c[8]; cpha_b = c[7];
    idx = c[7] ? 5'd16 : 5'd15;
    cap = '0; spat = p; edges = 0;
  endtask

  task automatic xfer(string tag, logic [15:0] c, logic [15:0] w, logic [15:0] p);
    logic [15:0] v;
    setup(c, p);
    wr(3'd0, w);
    wait_idle();
    rd(3'd0, v);
    chk({tag, " rx word"}, v, exp_rx(c[2], p));
    chk({tag, " tx bits"}, cap, exp_tx(c[2], w));
    chk({tag, " half period R6"}, e1 - e0, 2 * (c[15:9] + 1));
    chk({tag, " idle level R6"}, sclk, c[8]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, c;
    void'($urandom(32'd7431));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(3'd0, v); chk("R1 data", v, 0);
    rd(3'd2, v); chk("R1 ctrl", v, 0);
    rd(3'd4, v); chk("R1 stat", v, 0);
    chk("R1 irq", irq, 0); chk("R1 cs_n", cs_n, 1); chk("R1 sclk", sclk, 0);
    // R2 map
    wr(3'd2, 16'h1234); rd(3'd2, v); chk("R2 ctrl readback", v, 16'h1234);
    wr(3'd4, 16'hFFFF); rd(3'd4, v); chk("R2 status write ignored", v, 0);
    wr(3'd6, 16'hBEEF); rd(3'd6, v); chk("R2 unmapped read", v, 0);
    rd(3'd0, v); chk("R2 unmapped write no effect data", v, 0);
    rd(3'd2, v); chk("R2 unmapped write no effect ctrl", v, 16'h1234);
    rd(3'd1, v); chk("R2 odd offset read", v, 0);
    wr(3'd2, 16'h0000);
    // R4 word mode, R7 early sample
    xfer("R4 R7 word mode0", mk_ctrl(7'd0, 0, 0, 0, 0, 1, 1), 16'h3C81, 16'hC3E7);
    // R5 byte mode, R7 late sample, idle high
    xfer("R5 R7 byte mode1", mk_ctrl(7'd2, 1, 1, 0, 0, 0, 1), 16'hBE5A, 16'h96F0);
    xfer("R4 R7 word mode1", mk_ctrl(7'd1, 0, 1, 0, 0, 1, 1), 16'hA503, 16'h0F5A);
    // R3 busy, chip select, write while busy ignored; R8 completion
    c = mk_ctrl(7'd3, 0, 0, 0, 0, 1, 1);
    setup(c, 16'h5AA5);
    wr(3'd0, 16'h81C3);
    rd(3'd4, v); chk("R3 busy set", v, 1);
    chk("R3 cs_n low", cs_n, 0);
    repeat (40) @(negedge clk);
    wr(3'd0, 16'hFFFF);
    chk("R3 cs_n still low", cs_n, 0);
    wait_idle();
    chk("R3 cs_n high after", cs_n, 1);
    rd(3'd4, v); chk("R8 status after done", v, 2);
    rd(3'd0, v); chk("R3 R8 rx unaffected", v, 16'h5AA5);
    chk("R3 tx unaffected", cap, 16'h81C3);
    rd(3'd4, v); chk("R9 read clears full", v, 0);
    // R10 interrupt
    wr(3'd2, mk_ctrl(7'd0, 0, 0, 1, 0, 0, 1));
    @(negedge clk); chk("R10 idle irq", irq, 1);
    setup(mk_ctrl(7'd0, 0, 0, 0, 1, 0, 1), 16'h1100);
    chk("R10 no rx yet", irq, 0);
    wr(3'd0, 16'h0042);
    wait_idle();
    chk("R10 rx irq", irq, 1);
    wr(3'd2, mk_ctrl(7'd0, 0, 0, 1, 1, 0, 0));
    @(negedge clk); chk("R10 disabled", irq, 0);
    wr(3'd2, mk_ctrl(7'd0, 0, 0, 1, 1, 0, 1));
    setup(mk_ctrl(7'd0, 0, 0, 1, 0, 0, 1), 16'h2200);
    wr(3'd0, 16'h0011);
    chk("R10 busy masks idle irq", irq, 0);
    wait_idle(); rd(3'd0, v);
    setup(mk_ctrl(7'd0, 0, 0, 0, 1, 0, 1), 16'h3300);
    wr(3'd0, 16'h0022); wait_idle();
    rd(3'd0, v); chk("R10 rx irq after read", irq, 0);
    // R9 collision: leave a word unread, then read on the completion edge
    c = mk_ctrl(7'd0, 0, 0, 0, 0, 1, 1);
    setup(c, 16'h1357);
    wr(3'd0, 16'h0001); wait_idle();
    setup(c, 16'h2468);
    wr(3'd0, 16'h0002);
    repeat (62) @(negedge clk);
    rd(3'd0, v); chk("R9 collision returns old", v, 16'h1357);
    rd(3'd4, v); chk("R9 collision full kept", v, 2);
    rd(3'd0, v); chk("R9 new word", v, 16'h2468);
    rd(3'd4, v); chk("R9 cleared", v, 0);
    // random mix
    for (int k = 0; k < 24; k++) begin
      logic [15:0] rc, rw, rp;
      rc = mk_ctrl(7'($urandom_range(0, 3)), 1'($urandom), 1'($urandom), 0, 0, 1'($urandom), 1);
      rw = 16'($urandom); rp = 16'($urandom);
      xfer(rc[2] ? "R4 random" : "R5 random", rc, rw, rp);
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule